// File: doc/BRIEF.md
# Banked Scratchpad Access Arbiter

This block sits in front of a banked on-chip scratchpad and decides, every cycle, which of several requesters may touch the memory. The banks are split into bank groups, and each group offers two port sets per cycle. A group can serve two reads, or one read together with one write. Two accesses to the same bank never share a cycle, and two writes never share a group. The storage array itself lives elsewhere. This block only produces the per-requester ready signals.

Each requester drives a valid, a write flag and an address. The bank and the bank group come from fixed bit fields of that address. Requests are considered one by one, starting at a rotating priority pointer. A request is granted when it fits beside the accesses already granted in the same cycle. A refused requester keeps its request asserted and is served in a later cycle. The pointer moves on by one after every cycle in which some valid request was refused, so every requester reaches the head of the order within a bounded number of cycles.

Top module: `sca_arbiter`

## Requirements
- R1: For requester i, the bank index is req_addr bits [BANK_LSB +: log2(BANKS_PER_GROUP)] of its address slot. The group index is the log2(N_GROUPS) bits directly above the bank field. All other address bits have no effect on grants.
- R2: No bank group has more than two granted accesses in one cycle.
- R3: No bank group has more than one granted write in one cycle.
- R4: No two granted accesses in one cycle target the same bank, whether both are reads or one is a write.
- R5: req_ready[i] is high only when req_valid[i] is high.
- R6: The valid request of the requester at the priority pointer is always granted.
- R7: The priority pointer is 0 after reset. After a cycle in which at least one valid request was refused, it advances by one, wrapping from N_REQ-1 to 0. Otherwise it holds.
- R8: Requests are visited in order pointer, pointer+1, … (modulo N_REQ). A request is granted exactly when adding it to the earlier grants breaks none of R2, R3 and R4. Any refused valid request therefore collides with the granted set.
- R9: A requester that keeps a request valid is refused for at most N_REQ-1 consecutive cycles.
- R10: While rst_n is low, every req_ready bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously; deassertion is synchronous to clk |
| req_valid | input | N_REQ | Per-requester access request |
| req_write | input | N_REQ | Per-requester access kind: 1 = write, 0 = read |
| req_addr | input | N_REQ*ADDR_W | Packed addresses; requester i occupies bits [i*ADDR_W +: ADDR_W] |
| req_ready | output | N_REQ | Per-requester grant, combinational, in the same cycle as the request |

## Verification
The bound checker watches every cycle for these properties:
- the per-group and per-bank limits on the granted set;
- ready never appearing without valid;
- the head of the order always being served;
- the pointer stepping only after a refusal;
- the refusal of any request being justified by a collision with a granted one;
- the bound on consecutive refusals;
- the quiet outputs under reset.

Some behaviour only the bench scenarios can show. These are the field positions used for decoding, including the indifference to the remaining address bits. They also include the exact greedy choice among several legal grant sets for a given pointer. The bench shows these by sweeping every valid/kind/group/bank combination for four requesters against an arithmetic model. It also runs a contested-bank scenario to show fair service.

// File: rtl/sca_pkg.sv
`timescale 1ns/1ps
package sca_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;
endpackage

// File: rtl/sca_decode.sv
`timescale 1ns/1ps
module sca_decode
  import sca_pkg::*;
#(
  parameter int N_REQ    = 4,
  parameter int ADDR_W   = 12,
  parameter int BANK_LSB = 2,
  parameter int BANK_W   = 2,
  parameter int GROUP_W  = 1
) (
  input  logic [N_REQ-1:0]        valid_i,
  input  logic [N_REQ-1:0]        write_i,
  input  logic [N_REQ*ADDR_W-1:0] addr_i,
  output acc_kind_t               kind_o [N_REQ],
  output logic [GROUP_W-1:0]      grp_o  [N_REQ],
  output logic [BANK_W-1:0]       bnk_o  [N_REQ]
);
  localparam int GRP_LSB = BANK_LSB + BANK_W;

  for (genvar i = 0; i < N_REQ; i++) begin : g_req
    always_comb begin
      if (!valid_i[i])     kind_o[i] = ACC_IDLE;
      else if (write_i[i]) kind_o[i] = ACC_WRITE;
      else                 kind_o[i] = ACC_READ;
      bnk_o[i] = addr_i[i*ADDR_W + BANK_LSB +: BANK_W];
      grp_o[i] = addr_i[i*ADDR_W + GRP_LSB +: GROUP_W];
    end
  end
endmodule

// File: rtl/sca_grant.sv
`timescale 1ns/1ps
module sca_grant
  import sca_pkg::*;
#(
  parameter int N_REQ           = 4,
  parameter int N_GROUPS        = 2,
  parameter int BANKS_PER_GROUP = 4,
  parameter int BANK_W          = 2,
  parameter int GROUP_W         = 1,
  parameter int PTR_W           = 2
) (
  input  acc_kind_t          kind_i [N_REQ],
  input  logic [GROUP_W-1:0] grp_i  [N_REQ],
  input  logic [BANK_W-1:0]  bnk_i  [N_REQ],
  input  logic [PTR_W-1:0]   ptr_i,
  output logic [N_REQ-1:0]   grant_o
);
  logic [1:0]                 grp_load [N_GROUPS];
  logic                       grp_wr   [N_GROUPS];
  logic [BANKS_PER_GROUP-1:0] bank_busy[N_GROUPS];
  logic [PTR_W:0]             slot;
  logic [PTR_W-1:0]           idx;
  logic [GROUP_W-1:0]         g;
  logic [BANK_W-1:0]          b;
  logic                       fits;

  always_comb begin
    grant_o = '0;
    slot    = '0;
    idx     = '0;
    g       = '0;
    b       = '0;
    fits    = 1'b0;
    for (int j = 0; j < N_GROUPS; j++) begin
      grp_load[j]  = 2'd0;
      grp_wr[j]    = 1'b0;
      bank_busy[j] = '0;
    end
    for (int k = 0; k < N_REQ; k++) begin
      slot = {1'b0, ptr_i} + (PTR_W+1)'(k);
      if (slot >= (PTR_W+1)'(N_REQ)) slot = slot - (PTR_W+1)'(N_REQ);
      idx  = slot[PTR_W-1:0];
      g    = grp_i[idx];
      b    = bnk_i[idx];
      fits = (kind_i[idx] != ACC_IDLE) && (grp_load[g] < 2'd2) && !bank_busy[g][b]
             && !((kind_i[idx] == ACC_WRITE) && grp_wr[g]);
      if (fits) begin
        grant_o[idx]    = 1'b1;
        grp_load[g]     = grp_load[g] + 2'd1;
        bank_busy[g][b] = 1'b1;
        if (kind_i[idx] == ACC_WRITE) grp_wr[g] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sca_prio.sv
`timescale 1ns/1ps
module sca_prio #(
  parameter int N_REQ = 4,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conflict_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = conflict_i;
    if (ptr_q == PTR_W'(N_REQ-1)) ptr_d = '0;
    else                          ptr_d = ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/sca_arbiter.sv
`timescale 1ns/1ps
module sca_arbiter
  import sca_pkg::*;
#(
  parameter int N_REQ           = 4,
  parameter int N_GROUPS        = 2,
  parameter int BANKS_PER_GROUP = 4,
  parameter int ADDR_W          = 12,
  parameter int BANK_LSB        = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_REQ-1:0]        req_valid,
  input  logic [N_REQ-1:0]        req_write,
  input  logic [N_REQ*ADDR_W-1:0] req_addr,
  output logic [N_REQ-1:0]        req_ready
);
  localparam int BANK_W  = $clog2(BANKS_PER_GROUP);
  localparam int GROUP_W = $clog2(N_GROUPS);
  localparam int PTR_W   = $clog2(N_REQ);

  acc_kind_t          kind [N_REQ];
  logic [GROUP_W-1:0] grp  [N_REQ];
  logic [BANK_W-1:0]  bnk  [N_REQ];
  logic [N_REQ-1:0]   grant;
  logic [PTR_W-1:0]   prio_ptr;
  logic               conflict;

  sca_decode #(
    .N_REQ(N_REQ), .ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB),
    .BANK_W(BANK_W), .GROUP_W(GROUP_W)
  ) u_decode (
    .valid_i(req_valid), .write_i(req_write), .addr_i(req_addr),
    .kind_o(kind), .grp_o(grp), .bnk_o(bnk)
  );

  sca_grant #(
    .N_REQ(N_REQ), .N_GROUPS(N_GROUPS), .BANKS_PER_GROUP(BANKS_PER_GROUP),
    .BANK_W(BANK_W), .GROUP_W(GROUP_W), .PTR_W(PTR_W)
  ) u_grant (
    .kind_i(kind), .grp_i(grp), .bnk_i(bnk), .ptr_i(prio_ptr), .grant_o(grant)
  );

  assign conflict = |(req_valid & ~grant);

  sca_prio #(.N_REQ(N_REQ), .PTR_W(PTR_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .conflict_i(conflict), .ptr_o(prio_ptr)
  );

  assign req_ready = grant & {N_REQ{rst_n}};
endmodule

// File: rtl/sca_arbiter_chk.sv
`timescale 1ns/1ps
module sca_arbiter_chk #(
  parameter int N_REQ           = 4,
  parameter int N_GROUPS        = 2,
  parameter int BANKS_PER_GROUP = 4,
  parameter int ADDR_W          = 12,
  parameter int BANK_LSB        = 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [N_REQ-1:0]                req_valid,
  input logic [N_REQ-1:0]                req_write,
  input logic [N_REQ*ADDR_W-1:0]         req_addr,
  input logic [N_REQ-1:0]                req_ready,
  input logic [$clog2(N_REQ)-1:0]        prio_ptr
);
  localparam int BANK_W  = $clog2(BANKS_PER_GROUP);
  localparam int GROUP_W = $clog2(N_GROUPS);
  localparam int PTR_W   = $clog2(N_REQ);
  localparam int CNT_W   = $clog2(N_REQ + 1) + 1;

  logic [GROUP_W-1:0] c_grp [N_REQ];
  logic [BANK_W-1:0]  c_bnk [N_REQ];
  int                 g_cnt [N_GROUPS];
  int                 g_wr  [N_GROUPS];
  int                 b_cnt [N_GROUPS][BANKS_PER_GROUP];
  logic [N_REQ-1:0]   justified;
  logic [PTR_W-1:0]   ptr_inc;
  logic [CNT_W-1:0]   wait_cnt [N_REQ];

  always_comb begin
    for (int j = 0; j < N_GROUPS; j++) begin
      g_cnt[j] = 0;
      g_wr[j]  = 0;
      for (int m = 0; m < BANKS_PER_GROUP; m++) b_cnt[j][m] = 0;
    end
    for (int i = 0; i < N_REQ; i++) begin
      c_bnk[i] = req_addr[i*ADDR_W + BANK_LSB +: BANK_W];
      c_grp[i] = req_addr[i*ADDR_W + BANK_LSB + BANK_W +: GROUP_W];
      if (req_ready[i]) begin
        g_cnt[c_grp[i]] += 1;
        b_cnt[c_grp[i]][c_bnk[i]] += 1;
        if (req_write[i]) g_wr[c_grp[i]] += 1;
      end
    end
    for (int i = 0; i < N_REQ; i++)
      justified[i] = (g_cnt[c_grp[i]] >= 2) || (b_cnt[c_grp[i]][c_bnk[i]] >= 1)
                     || (req_write[i] && (g_wr[c_grp[i]] >= 1));
    ptr_inc = (prio_ptr == PTR_W'(N_REQ-1)) ? '0 : prio_ptr + PTR_W'(1);
  end

  for (genvar gi = 0; gi < N_GROUPS; gi++) begin : g_grp
    a_r2_group_two_max: assert property (@(posedge clk) disable iff (!rst_n)
      g_cnt[gi] <= 2);
    a_r3_group_one_write: assert property (@(posedge clk) disable iff (!rst_n)
      g_wr[gi] <= 1);
    for (genvar bi = 0; bi < BANKS_PER_GROUP; bi++) begin : g_bank
      a_r4_bank_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        b_cnt[gi][bi] <= 1);
    end
  end

  a_r5_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  a_r6_head_served: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid[prio_ptr] |-> req_ready[prio_ptr]);

  a_r7_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_valid & ~req_ready)) |=> (prio_ptr == $past(ptr_inc)));

  a_r7_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(req_valid & ~req_ready)) |=> $stable(prio_ptr));

  a_r8_refusal_justified: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_valid & ~req_ready & ~justified) == '0));

  for (genvar ri = 0; ri < N_REQ; ri++) begin : g_wait
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              wait_cnt[ri] <= '0;
      else if (req_valid[ri] && !req_ready[ri]) wait_cnt[ri] <= wait_cnt[ri] + CNT_W'(1);
      else                                     wait_cnt[ri] <= '0;
    end
    a_r9_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
      wait_cnt[ri] < CNT_W'(N_REQ));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r10_quiet_in_reset: assert (req_ready == '0);
    end
  end
endmodule

bind sca_arbiter sca_arbiter_chk #(
  .N_REQ(N_REQ), .N_GROUPS(N_GROUPS), .BANKS_PER_GROUP(BANKS_PER_GROUP),
  .ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_ready(req_ready), .prio_ptr(prio_ptr)
);

// File: tb/tb_sca_arbiter.sv
`timescale 1ns/1ps
module tb_sca_arbiter;
  localparam int NR = 4;
  localparam int AW = 8;

  logic          clk;
  logic          rst_n;
  logic [NR-1:0] req_valid;
  logic [NR-1:0] req_write;
  logic [NR*AW-1:0] req_addr;
  logic [NR-1:0] req_ready;

  int checks;
  int failures;
  bit done;
  int mptr;
  int tg [NR];
  int tb [NR];

  sca_arbiter #(
    .N_REQ(NR), .N_GROUPS(2), .BANKS_PER_GROUP(2), .ADDR_W(AW), .BANK_LSB(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(req_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Greedy model: visit from the pointer, grant when group load < 2, bank free, no second write.
  function automatic logic [NR-1:0] model_ready(input int p);
    int load [2];
    int wr [2];
    bit busy [2][2];
    logic [NR-1:0] r;
    r = '0;
    for (int j = 0; j < 2; j++) begin
      load[j] = 0; wr[j] = 0; busy[j][0] = 0; busy[j][1] = 0;
    end
    for (int k = 0; k < NR; k++) begin
      int i;
      i = (p + k) % NR;
      if (req_valid[i] && load[tg[i]] < 2 && !busy[tg[i]][tb[i]] && !(req_write[i] && wr[tg[i]] > 0)) begin
        r[i] = 1'b1;
        load[tg[i]]++;
        busy[tg[i]][tb[i]] = 1;
        if (req_write[i]) wr[tg[i]]++;
      end
    end
    return r;
  endfunction

  task automatic check_rules();
    int load [2];
    int wr [2];
    int bc [2][2];
    bit ok2, ok3, ok4;
    for (int j = 0; j < 2; j++) begin
      load[j] = 0; wr[j] = 0; bc[j][0] = 0; bc[j][1] = 0;
    end
    for (int i = 0; i < NR; i++) begin
      if (req_ready[i]) begin
        load[tg[i]]++;
        bc[tg[i]][tb[i]]++;
        if (req_write[i]) wr[tg[i]]++;
      end
    end
    ok2 = (load[0] <= 2) && (load[1] <= 2);
    ok3 = (wr[0] <= 1) && (wr[1] <= 1);
    ok4 = (bc[0][0] <= 1) && (bc[0][1] <= 1) && (bc[1][0] <= 1) && (bc[1][1] <= 1);
    check(ok2, "R2 group load", load[0] * 16 + load[1], 2);
    check(ok3, "R3 group writes", wr[0] * 16 + wr[1], 1);
    check(ok4, "R4 bank sharing", int'(req_ready), int'(req_ready));
    check((req_ready & ~req_valid) == '0, "R5 ready without valid", int'(req_ready), int'(req_valid));
  endtask

  // Address layout under test: [1:0] offset, [2] bank, [3] group, [7:4] unrelated.
  task automatic set_req(input int i, input bit v, input bit w, input int g, input int b);
    req_valid[i] = v;
    req_write[i] = w;
    tg[i] = g;
    tb[i] = b;
    req_addr[i*AW +: AW] = {4'($urandom), 1'(g), 1'(b), 2'($urandom)};
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 0; mptr = 0;
    rst_n = 1'b0;
    req_valid = '0; req_write = '0; req_addr = '0;
    for (int i = 0; i < NR; i++) begin tg[i] = 0; tb[i] = 0; end

    // R10: requests present during reset get no ready.
    repeat (2) @(negedge clk);
    for (int i = 0; i < NR; i++) set_req(i, 1'b1, 1'b0, i % 2, i / 2);
    #1;
    check(req_ready == '0, "R10 ready in reset", int'(req_ready), 0);
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = '0;

    // Exhaustive sweep: 9 choices per requester (idle, or read/write x group x bank).
    for (int c = 0; c < 6561; c++) begin
      int v;
      logic [NR-1:0] exp;
      @(negedge clk);
      v = c;
      for (int i = 0; i < NR; i++) begin
        int d;
        d = v % 9;
        v = v / 9;
        if (d == 0) set_req(i, 1'b0, 1'b0, 0, 0);
        else        set_req(i, 1'b1, 1'(((d - 1) >> 2) & 1), ((d - 1) >> 1) & 1, (d - 1) & 1);
      end
      #1;
      exp = model_ready(mptr);
      // R1 field decode, R6 head served, R7 pointer history, R8 greedy choice
      check(req_ready == exp, "R1/R6/R7/R8 grant vector", int'(req_ready), int'(exp));
      check_rules();
      @(posedge clk);
      if (|(req_valid & ~exp)) mptr = (mptr + 1) % NR;
    end

    // R9: all requesters read the same bank and hold until served.
    begin
      logic [NR-1:0] pending;
      int waits [NR];
      pending = '1;
      for (int i = 0; i < NR; i++) waits[i] = 0;
      for (int cyc = 0; cyc < 3 * NR && pending != '0; cyc++) begin
        @(negedge clk);
        for (int i = 0; i < NR; i++) set_req(i, pending[i], 1'b0, 1, 1);
        #1;
        check($countones(req_ready) == 1, "R4 one grant per contested bank", $countones(req_ready), 1);
        for (int i = 0; i < NR; i++) begin
          if (pending[i] && req_ready[i]) pending[i] = 1'b0;
          else if (pending[i]) waits[i]++;
        end
      end
      @(negedge clk);
      req_valid = '0;
      check(pending == '0, "R9 all served", int'(pending), 0);
      for (int i = 0; i < NR; i++)
        check(waits[i] <= NR - 1, "R9 refusal streak", waits[i], NR - 1);
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule